// File: doc/BRIEF.md
# Bit-sliced precision-scalable multiplier

This block multiplies two signed operands whose precision is chosen per operation, anywhere from 1 to 32 bits. The multiplicand is cut into slices of a fixed width set by a parameter (1, 8 or 16 bits). Each cycle, one slice is multiplied by the full-width multiplier, and an accumulator adds the result at the slice's weight.

The number of passes is the number of slices that the programmed precision needs. An operation at low precision therefore finishes in fewer cycles than one at full precision. A slice width of 1 gives a bit-serial unit.

Operands are first cut down to the requested precision. Bits above the precision are discarded and replaced by copies of the operand's new sign bit. The caller pulses a start request while the unit is idle and later receives a 64-bit two's-complement product together with a one-cycle completion pulse.

Top module: `prec_slice_mul`

## Requirements
- R1: After reset, busy_o, done_o and product_o are all zero.
- R2: product_o at a done_o pulse equals the signed product of the two narrowed operands, as a 64-bit two's-complement value.
- R3: For an effective precision w, operand bits at positions w and above have no effect. Each operand is read as its low w bits, sign-extended from bit w-1.
- R4: width_i values from 1 to 32 give that precision. The value 0 gives precision 1, and values above 32 give precision 32.
- R5: done_o rises exactly ceil(w/SLICE_W)+1 clock edges after the edge that accepts the start. busy_o is high from the accepting edge until the edge that raises done_o.
- R6: done_o is high for one cycle only, and product_o keeps its value until the next done_o pulse.
- R7: A start request while busy_o is high is ignored: it does not change the running result or its latency.
- R8: A start request in the cycle where done_o is high is accepted, because busy_o is low in that cycle, so operations can run back to back.
- R9: With SLICE_W = 1 the latency is w+1 cycles; with SLICE_W = 16 it is 2 cycles for w up to 16 and 3 cycles above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted when busy_o is low |
| width_i | input | PREC_W (6) | Requested operand precision in bits |
| mcand_i | input | DATA_W (32) | Multiplicand, sliced |
| mplier_i | input | DATA_W (32) | Multiplier, used at full width |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse, product_o valid |
| product_o | output | 2*DATA_W (64) | Registered signed product |

## Verification
The bench builds three copies of the block side by side, with SLICE_W of 8, 1 and 16, and drives them from shared operand inputs.

- **Exhaustive precisions.** For precisions 1 to 4, every operand pair is applied to the 8-bit and bit-serial copies, with random junk in the bits above the precision. This covers sign handling of the top slice and narrowing in full.
- **Width sweep.** All widths from 1 to 32 run on every copy with extreme values (most negative, most positive, minus one) and random values. This exposes each step in latency at the slice boundaries.
- **Corner sequences.** Out-of-range width codes, ignored starts and back-to-back starts are run as separate sequences.

// File: rtl/prec_mul_pkg.sv
package prec_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mul_state_e;
endpackage

// File: rtl/opnd_narrow.sv
module opnd_narrow #(
  parameter int DATA_W  = 32,
  parameter int PREC_W  = 6,
  parameter int SLICE_W = 8,
  parameter int CNT_W   = 3
) (
  input  logic [PREC_W-1:0] width_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic [CNT_W-1:0]  nslice_o
);
  localparam int SLICE_LG = $clog2(SLICE_W);

  logic [PREC_W-1:0] eff;
  logic [PREC_W-1:0] sign_pos;
  logic [PREC_W:0]   round_up;

  // clamp the requested precision into 1..DATA_W
  always_comb begin
    if (width_i == '0)
      eff = PREC_W'(1);
    else if (width_i > PREC_W'(DATA_W))
      eff = PREC_W'(DATA_W);
    else
      eff = width_i;
  end

  assign sign_pos = eff - PREC_W'(1);

  // keep low eff bits, copy the new sign bit above them
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      a_o[i] = (PREC_W'(i) < eff) ? a_i[i] : a_i[sign_pos];
      b_o[i] = (PREC_W'(i) < eff) ? b_i[i] : b_i[sign_pos];
    end
  end

  assign round_up = {1'b0, eff} + (PREC_W+1)'(SLICE_W - 1);
  assign nslice_o = CNT_W'(round_up >> SLICE_LG);
endmodule

// File: rtl/slice_pp.sv
module slice_pp #(
  parameter int SLICE_W = 8,
  parameter int ACC_W   = 64
) (
  input  logic [SLICE_W-1:0] slice_i,
  input  logic               top_i,
  input  logic [ACC_W-1:0]   mplier_i,
  output logic [ACC_W-1:0]   pp_o
);
  generate
    if (SLICE_W == 1) begin : g_serial
      // one bit: weight +1, or -1 when it is the signed top slice
      always_comb begin
        if (!slice_i[0])
          pp_o = '0;
        else if (top_i)
          pp_o = '0 - mplier_i;
        else
          pp_o = mplier_i;
      end
    end else begin : g_wide
      logic signed [SLICE_W:0]         s_ext;
      logic signed [ACC_W-1:0]         m_s;
      logic signed [ACC_W+SLICE_W:0]   full;
      always_comb begin
        s_ext = $signed({top_i & slice_i[SLICE_W-1], slice_i});
        m_s   = $signed(mplier_i);
        full  = s_ext * m_s;
        pp_o  = full[ACC_W-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/slice_ctrl.sv
module slice_ctrl
  import prec_mul_pkg::*;
#(
  parameter int CNT_W      = 3,
  parameter int MAX_SLICES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] nslice_i,
  output logic             load_o,
  output logic             step_o,
  output logic             last_o,
  output logic             fin_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] nslice_o
);
  mul_state_e       state_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] k_q;

  assign load_o   = start_i && (state_q == ST_IDLE);
  assign step_o   = (state_q == ST_RUN);
  assign fin_o    = (state_q == ST_FIN);
  assign busy_o   = (state_q != ST_IDLE);
  assign last_o   = step_o && (idx_q == k_q - CNT_W'(1));
  assign nslice_o = k_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      k_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (load_o) begin
          k_q     <= nslice_i;
          idx_q   <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          idx_q <= idx_q + CNT_W'(1);
          if (last_o) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(k_q)); // R7

  AST_SLICE_RANGE: assert property (@(posedge clk) disable iff (rst)
    load_o |-> (nslice_i >= CNT_W'(1) && nslice_i <= CNT_W'(MAX_SLICES))); // R4

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    step_o |-> (idx_q < k_q)); // R5
endmodule

// File: rtl/prec_slice_mul.sv
module prec_slice_mul #(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 8,
  parameter int PREC_W  = $clog2(DATA_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [PREC_W-1:0]   width_i,
  input  logic [DATA_W-1:0]   mcand_i,
  input  logic [DATA_W-1:0]   mplier_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [2*DATA_W-1:0] product_o
);
  localparam int ACC_W      = 2 * DATA_W;
  localparam int MAX_SLICES = DATA_W / SLICE_W;
  localparam int CNT_W      = $clog2(MAX_SLICES + 1);

  logic [DATA_W-1:0] a_n, b_n;
  logic [CNT_W-1:0]  nslice, k_cur;
  logic              load, step, last, fin;
  logic [DATA_W-1:0] a_sh;
  logic [ACC_W-1:0]  b_sh, acc_q, pp, product_q;
  logic              done_q;

  opnd_narrow #(
    .DATA_W(DATA_W), .PREC_W(PREC_W), .SLICE_W(SLICE_W), .CNT_W(CNT_W)
  ) u_narrow (
    .width_i(width_i), .a_i(mcand_i), .b_i(mplier_i),
    .a_o(a_n), .b_o(b_n), .nslice_o(nslice)
  );

  slice_ctrl #(.CNT_W(CNT_W), .MAX_SLICES(MAX_SLICES)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .nslice_i(nslice),
    .load_o(load), .step_o(step), .last_o(last), .fin_o(fin),
    .busy_o(busy_o), .nslice_o(k_cur)
  );

  slice_pp #(.SLICE_W(SLICE_W), .ACC_W(ACC_W)) u_pp (
    .slice_i(a_sh[SLICE_W-1:0]), .top_i(last), .mplier_i(b_sh), .pp_o(pp)
  );

  // slices leave least significant first; multiplier moves up in step
  always_ff @(posedge clk) begin
    if (rst) begin
      a_sh      <= '0;
      b_sh      <= '0;
      acc_q     <= '0;
      product_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        a_sh  <= a_n;
        b_sh  <= {{DATA_W{b_n[DATA_W-1]}}, b_n};
        acc_q <= '0;
      end else if (step) begin
        acc_q <= acc_q + pp;
        a_sh  <= a_sh >> SLICE_W;
        b_sh  <= b_sh << SLICE_W;
      end else if (fin) begin
        product_q <= acc_q;
        done_q    <= 1'b1;
      end
    end
  end

  assign done_o    = done_q;
  assign product_o = product_q;

  // cycles since the accepting edge, for the latency check only
  logic [CNT_W:0] lat_q;
  always_ff @(posedge clk) begin
    if (rst)         lat_q <= '0;
    else if (load)   lat_q <= '0;
    else if (busy_o) lat_q <= lat_q + (CNT_W+1)'(1);
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (lat_q == {1'b0, k_cur} + (CNT_W+1)'(1))); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R8

  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(product_o)); // R6
endmodule

// File: tb/tb_prec_slice_mul.sv
`timescale 1ns/1ps
module tb_prec_slice_mul;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [5:0]  wcode = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        start [3];
  logic        busy  [3];
  logic        done  [3];
  logic [63:0] prod  [3];

  int n_chk = 0, n_bad = 0;

  // index 0: slice 8, index 1: slice 1, index 2: slice 16
  prec_slice_mul #(.DATA_W(32), .SLICE_W(8)) dut (
    .clk(clk), .rst(rst), .start_i(start[0]), .width_i(wcode),
    .mcand_i(op_a), .mplier_i(op_b), .busy_o(busy[0]), .done_o(done[0]),
    .product_o(prod[0]));
  prec_slice_mul #(.DATA_W(32), .SLICE_W(1)) dut_s1 (
    .clk(clk), .rst(rst), .start_i(start[1]), .width_i(wcode),
    .mcand_i(op_a), .mplier_i(op_b), .busy_o(busy[1]), .done_o(done[1]),
    .product_o(prod[1]));
  prec_slice_mul #(.DATA_W(32), .SLICE_W(16)) dut_s16 (
    .clk(clk), .rst(rst), .start_i(start[2]), .width_i(wcode),
    .mcand_i(op_a), .mplier_i(op_b), .busy_o(busy[2]), .done_o(done[2]),
    .product_o(prod[2]));

  function automatic int sw(int d);
    return (d == 0) ? 8 : (d == 1) ? 1 : 16;
  endfunction

  function automatic int effw(logic [5:0] c);
    if (c == 0) return 1;
    if (c > 32) return 32;
    return int'(c);
  endfunction

  function automatic longint narrow(logic [31:0] v, int w);
    longint x = longint'(v) & ((longint'(1) << w) - 1);
    if (x >= (longint'(1) << (w - 1))) x = x - (longint'(1) << w);
    return x;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // waits for done and checks latency and product for the given request
  task automatic finish_op(int d, int cyc0, logic [5:0] wc, logic [31:0] a, b,
                           string ptag);
    int cyc = cyc0;
    int w = effw(wc);
    int el = (w + sw(d) - 1) / sw(d) + 1;
    longint ep = narrow(a, w) * narrow(b, w);
    while (!done[d] && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == el, "R5 latency", cyc, el);
    if (d != 0) chk(cyc == el, "R9 slice-width latency", cyc, el);
    chk(prod[d] == ep, ptag, prod[d], ep);
  endtask

  task automatic run_op(int d, logic [5:0] wc, logic [31:0] a, b,
                        string ptag, bit nowait);
    if (!nowait) @(negedge clk);
    wcode = wc; op_a = a; op_b = b; start[d] = 1'b1;
    @(negedge clk);
    start[d] = 1'b0;
    finish_op(d, 0, wc, a, b, ptag);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    for (int d = 0; d < 3; d++) start[d] = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    for (int d = 0; d < 3; d++) begin
      chk(busy[d] == 1'b0, "R1 busy", busy[d], 0);
      chk(done[d] == 1'b0, "R1 done", done[d], 0);
      chk(prod[d] == 64'd0, "R1 product", prod[d], 0);
    end

    // R3 exhaustive small precisions with junk in the high bits
    for (int d = 0; d < 2; d++)
      for (int w = 1; w <= 4; w++)
        for (int a = 0; a < (1 << w); a++)
          for (int b = 0; b < (1 << w); b++) begin
            logic [31:0] ja = $urandom << w;
            logic [31:0] jb = $urandom << w;
            run_op(d, 6'(w), ja | 32'(a), jb | 32'(b), "R3 narrowing", 1'b0);
          end

    // R2 width sweep with extreme and random values on all slice widths
    for (int d = 0; d < 3; d++)
      for (int w = 1; w <= 32; w++) begin
        logic [31:0] mn = 32'(longint'(1) << (w - 1));
        logic [31:0] mx = mn - 32'd1;
        run_op(d, 6'(w), mn, mn, "R2 min*min", 1'b0);
        run_op(d, 6'(w), mx, mn, "R2 max*min", 1'b0);
        run_op(d, 6'(w), 32'hFFFF_FFFF, mx, "R2 -1*max", 1'b0);
        run_op(d, 6'(w), $urandom, $urandom, "R2 random", 1'b0);
      end

    // R4 out-of-range width codes
    for (int d = 0; d < 3; d++) begin
      run_op(d, 6'd0, 32'h0000_0003, 32'h0000_0001, "R4 code 0", 1'b0);
      run_op(d, 6'd33, 32'h8000_0001, 32'h7FFF_FFFF, "R4 code 33", 1'b0);
      run_op(d, 6'd63, 32'hDEAD_BEEF, 32'h1234_5678, "R4 code 63", 1'b0);
    end

    // R7 start while busy is ignored
    for (int d = 0; d < 3; d++) begin
      @(negedge clk);
      wcode = 6'd32; op_a = 32'hFFFF_FF85; op_b = 32'h0001_2345; start[d] = 1'b1;
      @(negedge clk);
      chk(busy[d] == 1'b1, "R5 busy after accept", busy[d], 1);
      wcode = 6'd3; op_a = 32'h7; op_b = 32'h5;
      @(negedge clk);
      start[d] = 1'b0;
      finish_op(d, 1, 6'd32, 32'hFFFF_FF85, 32'h0001_2345, "R7 ignored start");
    end

    // R8 back to back: new start in the done cycle; R6 hold afterwards
    for (int d = 0; d < 3; d++) begin
      run_op(d, 6'd12, 32'h0000_0ABC, 32'h0000_0123, "R2 first", 1'b0);
      chk(busy[d] == 1'b0, "R8 idle at done", busy[d], 0);
      run_op(d, 6'd20, 32'h000F_0001, 32'h0008_0000, "R8 back to back", 1'b1);
      @(negedge clk);
      chk(done[d] == 1'b0, "R6 single pulse", done[d], 0);
      wcode = 6'd5; op_a = 32'h1F; op_b = 32'h3;
      repeat (3) @(negedge clk);
      chk(prod[d] == 64'(narrow(32'h000F_0001, 20) * narrow(32'h0008_0000, 20)),
          "R6 product hold", prod[d],
          narrow(32'h000F_0001, 20) * narrow(32'h0008_0000, 20));
    end

    summary();
  end
endmodule